// File: doc/BRIEF.md
# Segmented Address Translation Checker

This block turns one memory access, given as a segment choice plus a 32-bit offset, into a linear address. It checks the access against the cached attributes of the segment it goes through. The caller gives the access kind, which is an instruction fetch, a stack access or any other data access. It may also give an explicit segment override, and it gives the offset, a write flag and the current privilege level. The block picks one of several segment registers. For each register it holds a cached base, a limit, an executable bit, a read/write bit, a descriptor privilege level and a null marker. It adds the base to the offset and judges whether the access is allowed.

The result comes out one clock after the request. It has a done strobe, an ok flag, a fault code and the computed address. Paging is not modelled, so the address that comes out is also the physical address and needs no further step. Fetching descriptors into the cache is done elsewhere, and so are expand-down segments.

Top module: `seg_xlate_unit`

## Requirements
- R1: While reset is high, and in the first cycle after reset, rsp_done and rsp_ok are 0 and rsp_fault is 0.
- R2: A request with req_valid high at a clock edge gives rsp_done high in the next cycle. That response carries rsp_addr equal to the selected segment base plus req_offset, taken modulo 2^ADDR_W.
- R3: Without an override, the segment is chosen from req_kind. Code 0 is a fetch and uses register 0. Code 1 is a stack access and uses register 1. Code 2 is a data access and uses register 2. Code 3 is treated as a data access.
- R4: With req_ovr_en high, a stack or data access uses register req_ovr_sel instead. For a fetch the override is ignored and register 0 is still used.
- R5: An access gets fault code 1 (null segment) when the chosen register has its seg_null bit set. It also gets code 1 when req_ovr_sel names an index of NUM_SEGS or above.
- R6: An access gets fault code 2 (privilege) when the chosen register's level is numerically below cur_pl.
- R7: A fetch through a register whose seg_exec bit is 0 gets fault code 3 (type).
- R8: A write gets fault code 3 unless the register is a data segment (seg_exec 0) with seg_rw 1. A read through a code segment (seg_exec 1) gets code 3 when seg_rw is 0, which marks execute-only. Reads from data segments are always allowed.
- R9: An access gets fault code 4 (limit) when req_offset is greater than the register's limit. An offset equal to the limit is allowed.
- R10: When several faults apply, the code reported follows a fixed priority. Null comes first, then privilege, then type, then limit.
- R11: rsp_ok is high exactly when rsp_done is high and rsp_fault is 0. A cycle with no request gives rsp_done 0, rsp_ok 0 and rsp_fault 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | Access kind: 0 fetch, 1 stack, 2 or 3 data |
| req_ovr_en | input | 1 | Explicit segment override enable |
| req_ovr_sel | input | SEL_W | Override segment register index |
| req_offset | input | ADDR_W | Offset within the segment |
| req_write | input | 1 | 1 for a write, 0 for a read |
| cur_pl | input | 2 | Current privilege level |
| seg_base_flat | input | NUM_SEGS*ADDR_W | Cached bases, register i at bits i*ADDR_W upward |
| seg_limit_flat | input | NUM_SEGS*ADDR_W | Cached limits, same packing |
| seg_exec | input | NUM_SEGS | Executable (code) segment bit per register |
| seg_rw | input | NUM_SEGS | Writable for data, readable for code |
| seg_dpl_flat | input | NUM_SEGS*2 | Descriptor privilege level per register |
| seg_null | input | NUM_SEGS | Register holds the null selector |
| rsp_done | output | 1 | Response for last cycle's request |
| rsp_ok | output | 1 | Access allowed |
| rsp_fault | output | 3 | 0 none, 1 null, 2 privilege, 3 type, 4 limit |
| rsp_addr | output | ADDR_W | Linear (and physical) address |

## Verification
The bench builds the block with its defaults: ADDR_W of 32, NUM_SEGS of 6 and SEL_W of 3. With the 3-bit override field, indices 6 and 7 can be driven, and these reach the out-of-range null path. With the full 32-bit width, a base near the top of the space can be added to an offset that wraps past 2^32. A limit of all ones can also be set, so the limit compare is exercised at both ends. The reference model is run with one writable data register, one read-only register, one code register and one privilege-3 register. These let every fault code and every priority pairing appear.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_STACK = 2'd1,
        ACC_DATA  = 2'd2
    } acc_kind_e;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_NULL  = 3'd1,
        FLT_PRIV  = 3'd2,
        FLT_TYPE  = 3'd3,
        FLT_LIMIT = 3'd4
    } fault_e;

    // Implicit register slots
    localparam int SLOT_CODE  = 0;
    localparam int SLOT_STACK = 1;
    localparam int SLOT_DATA  = 2;

    typedef struct packed {
        logic       exec;
        logic       rw;
        logic [1:0] dpl;
        logic       nul;
    } seg_attr_t;

    typedef struct packed {
        logic   done;
        fault_e code;
    } chk_res_t;

    // Type rule: fetch needs code, write needs writable data,
    // read through code needs the readable bit.
    function automatic logic type_bad(input logic is_fetch, input logic is_write,
                                      input seg_attr_t a);
        if (is_fetch)
            return !a.exec;
        if (is_write)
            return a.exec || !a.rw;
        return a.exec && !a.rw;
    endfunction

    function automatic fault_e pick_fault(input logic f_null, input logic f_priv,
                                          input logic f_type, input logic f_limit);
        if (f_null)  return FLT_NULL;
        if (f_priv)  return FLT_PRIV;
        if (f_type)  return FLT_TYPE;
        if (f_limit) return FLT_LIMIT;
        return FLT_NONE;
    endfunction

endpackage

// File: rtl/seg_select.sv
module seg_select
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NUM_SEGS = 6,
    parameter int SEL_W    = 3
) (
    input  acc_kind_e                    kind,
    input  logic                         ovr_en,
    input  logic [SEL_W-1:0]             ovr_sel,
    input  logic [NUM_SEGS*ADDR_W-1:0]   base_flat,
    input  logic [NUM_SEGS*ADDR_W-1:0]   limit_flat,
    input  logic [NUM_SEGS-1:0]          exec_in,
    input  logic [NUM_SEGS-1:0]          rw_in,
    input  logic [NUM_SEGS*2-1:0]        dpl_flat,
    input  logic [NUM_SEGS-1:0]          null_in,
    output logic [ADDR_W-1:0]            sel_base,
    output logic [ADDR_W-1:0]            sel_limit,
    output seg_attr_t                    sel_attr
);

    logic [ADDR_W-1:0] base_arr  [NUM_SEGS];
    logic [ADDR_W-1:0] limit_arr [NUM_SEGS];
    seg_attr_t         attr_arr  [NUM_SEGS];

    genvar g;
    generate
        for (g = 0; g < NUM_SEGS; g++) begin : g_unpack
            assign base_arr[g]      = base_flat[g*ADDR_W +: ADDR_W];
            assign limit_arr[g]     = limit_flat[g*ADDR_W +: ADDR_W];
            assign attr_arr[g].exec = exec_in[g];
            assign attr_arr[g].rw   = rw_in[g];
            assign attr_arr[g].dpl  = dpl_flat[g*2 +: 2];
            assign attr_arr[g].nul  = null_in[g];
        end
    endgenerate

    logic [SEL_W-1:0] idx;

    always_comb begin
        unique case (kind)
            ACC_FETCH: idx = SEL_W'(SLOT_CODE);
            ACC_STACK: idx = SEL_W'(SLOT_STACK);
            default:   idx = SEL_W'(SLOT_DATA);
        endcase
        if (ovr_en && kind != ACC_FETCH)
            idx = ovr_sel;
    end

    // An index past the last register reads as a null segment
    always_comb begin
        sel_base  = '0;
        sel_limit = '0;
        sel_attr  = '{exec: 1'b0, rw: 1'b0, dpl: 2'd0, nul: 1'b1};
        for (int i = 0; i < NUM_SEGS; i++) begin
            if (int'(idx) == i) begin
                sel_base  = base_arr[i];
                sel_limit = limit_arr[i];
                sel_attr  = attr_arr[i];
            end
        end
    end

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              req_valid,
    input  acc_kind_e         kind,
    input  logic              is_write,
    input  logic [1:0]        cpl,
    input  logic [ADDR_W-1:0] offset,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  seg_attr_t         attr,
    output logic [ADDR_W-1:0] lin_addr,
    output chk_res_t          res
);

    logic f_null, f_priv, f_type, f_limit;

    assign lin_addr = base + offset;

    always_comb begin
        f_null  = attr.nul;
        f_priv  = attr.dpl < cpl;
        f_type  = type_bad(kind == ACC_FETCH, is_write, attr);
        f_limit = offset > limit;
        res.done = req_valid;
        res.code = req_valid ? pick_fault(f_null, f_priv, f_type, f_limit) : FLT_NONE;
    end

endmodule

// File: rtl/seg_resp_reg.sv
module seg_resp_reg
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  chk_res_t          res_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              done_q,
    output logic              ok_q,
    output fault_e            fault_q,
    output logic [ADDR_W-1:0] addr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            ok_q    <= 1'b0;
            fault_q <= FLT_NONE;
            addr_q  <= '0;
        end else begin
            done_q  <= res_in.done;
            ok_q    <= res_in.done && (res_in.code == FLT_NONE);
            fault_q <= res_in.code;
            addr_q  <= res_in.done ? addr_in : '0;
        end
    end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NUM_SEGS = 6,
    parameter int SEL_W    = $clog2(NUM_SEGS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [1:0]                  req_kind,
    input  logic                        req_ovr_en,
    input  logic [SEL_W-1:0]            req_ovr_sel,
    input  logic [ADDR_W-1:0]           req_offset,
    input  logic                        req_write,
    input  logic [1:0]                  cur_pl,
    input  logic [NUM_SEGS*ADDR_W-1:0]  seg_base_flat,
    input  logic [NUM_SEGS*ADDR_W-1:0]  seg_limit_flat,
    input  logic [NUM_SEGS-1:0]         seg_exec,
    input  logic [NUM_SEGS-1:0]         seg_rw,
    input  logic [NUM_SEGS*2-1:0]       seg_dpl_flat,
    input  logic [NUM_SEGS-1:0]         seg_null,
    output logic                        rsp_done,
    output logic                        rsp_ok,
    output logic [2:0]                  rsp_fault,
    output logic [ADDR_W-1:0]           rsp_addr
);

    acc_kind_e         kind;
    logic [ADDR_W-1:0] sel_base, sel_limit, lin_addr;
    seg_attr_t         sel_attr;
    chk_res_t          chk_res;
    fault_e            fault_q;

    assign kind = acc_kind_e'(req_kind);

    seg_select #(.ADDR_W(ADDR_W), .NUM_SEGS(NUM_SEGS), .SEL_W(SEL_W)) u_select (
        .kind       (kind),
        .ovr_en     (req_ovr_en),
        .ovr_sel    (req_ovr_sel),
        .base_flat  (seg_base_flat),
        .limit_flat (seg_limit_flat),
        .exec_in    (seg_exec),
        .rw_in      (seg_rw),
        .dpl_flat   (seg_dpl_flat),
        .null_in    (seg_null),
        .sel_base   (sel_base),
        .sel_limit  (sel_limit),
        .sel_attr   (sel_attr)
    );

    seg_check #(.ADDR_W(ADDR_W)) u_check (
        .req_valid (req_valid),
        .kind      (kind),
        .is_write  (req_write),
        .cpl       (cur_pl),
        .offset    (req_offset),
        .base      (sel_base),
        .limit     (sel_limit),
        .attr      (sel_attr),
        .lin_addr  (lin_addr),
        .res       (chk_res)
    );

    seg_resp_reg #(.ADDR_W(ADDR_W)) u_resp (
        .clk     (clk),
        .rst     (rst),
        .res_in  (chk_res),
        .addr_in (lin_addr),
        .done_q  (rsp_done),
        .ok_q    (rsp_ok),
        .fault_q (fault_q),
        .addr_q  (rsp_addr)
    );

    assign rsp_fault = fault_q;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] req_offset,
    input logic [ADDR_W-1:0] code_base,
    input logic [ADDR_W-1:0] code_limit,
    input logic              code_exec,
    input logic              code_null,
    input logic              rsp_done,
    input logic              rsp_ok,
    input logic [2:0]        rsp_fault,
    input logic [ADDR_W-1:0] rsp_addr
);

    logic is_fetch;
    assign is_fetch = req_valid && (req_kind == 2'd0);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!rsp_done && !rsp_ok && rsp_fault == 3'd0));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !rsp_done |-> (!rsp_ok && rsp_fault == 3'd0));

    assert_ok_means_clean_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (rsp_ok == (rsp_fault == 3'd0)));

    assert_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_done);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_done);

    // R4: a fetch always goes through register 0, override or not
    assert_fetch_addr_R4: assert property (@(posedge clk) disable iff (rst)
        is_fetch |=> (rsp_addr == $past(code_base + req_offset)));

    assert_fetch_null_R5: assert property (@(posedge clk) disable iff (rst)
        (is_fetch && code_null) |=> (rsp_fault == 3'd1));

    assert_fetch_exec_R7: assert property (@(posedge clk) disable iff (rst)
        (is_fetch && !code_exec) |=> (!rsp_ok && rsp_fault != 3'd0));

    assert_fetch_limit_R9: assert property (@(posedge clk) disable iff (rst)
        (is_fetch && req_offset > code_limit) |=> !rsp_ok);

endmodule

bind seg_xlate_unit seg_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_offset (req_offset),
    .code_base  (seg_base_flat[ADDR_W-1:0]),
    .code_limit (seg_limit_flat[ADDR_W-1:0]),
    .code_exec  (seg_exec[0]),
    .code_null  (seg_null[0]),
    .rsp_done   (rsp_done),
    .rsp_ok     (rsp_ok),
    .rsp_fault  (rsp_fault),
    .rsp_addr   (rsp_addr)
);

// File: tb/seg_xlate_unit_tb.sv
module seg_xlate_unit_tb;

    localparam int AW = 32;
    localparam int NS = 6;
    localparam int SW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'd0;
    logic          req_ovr_en = 1'b0;
    logic [SW-1:0] req_ovr_sel = '0;
    logic [AW-1:0] req_offset = '0;
    logic          req_write = 1'b0;
    logic [1:0]    cur_pl = 2'd0;

    logic [AW-1:0] tb_base [NS];
    logic [AW-1:0] tb_lim  [NS];
    logic          tb_exec [NS];
    logic          tb_rw   [NS];
    logic [1:0]    tb_dpl  [NS];
    logic          tb_null [NS];

    logic [NS*AW-1:0] base_flat, lim_flat;
    logic [NS-1:0]    exec_v, rw_v, null_v;
    logic [NS*2-1:0]  dpl_flat;

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            base_flat[i*AW +: AW] = tb_base[i];
            lim_flat[i*AW +: AW]  = tb_lim[i];
            exec_v[i]             = tb_exec[i];
            rw_v[i]               = tb_rw[i];
            null_v[i]             = tb_null[i];
            dpl_flat[i*2 +: 2]    = tb_dpl[i];
        end
    end

    logic          rsp_done, rsp_ok;
    logic [2:0]    rsp_fault;
    logic [AW-1:0] rsp_addr;

    seg_xlate_unit #(.ADDR_W(AW), .NUM_SEGS(NS), .SEL_W(SW)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_ovr_en(req_ovr_en), .req_ovr_sel(req_ovr_sel), .req_offset(req_offset),
        .req_write(req_write), .cur_pl(cur_pl), .seg_base_flat(base_flat),
        .seg_limit_flat(lim_flat), .seg_exec(exec_v), .seg_rw(rw_v),
        .seg_dpl_flat(dpl_flat), .seg_null(null_v), .rsp_done(rsp_done),
        .rsp_ok(rsp_ok), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    bit            q_done [$];
    bit            q_ok   [$];
    int            q_code [$];
    logic [AW-1:0] q_addr [$];
    string         q_tag  [$];

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Behavioural reference of one access
    task automatic model(input bit v, input int kind, input bit ovr, input int osel,
                         input logic [AW-1:0] off, input bit wr, input int cpl,
                         output bit e_ok, output int e_code, output logic [AW-1:0] e_addr);
        int  s;
        bit  nul, tbad;
        if (!v) begin
            e_ok = 0; e_code = 0; e_addr = '0;
            return;
        end
        case (kind)
            0: s = 0;
            1: s = 1;
            default: s = 2;
        endcase
        if (ovr && kind != 0) s = osel;
        nul = (s >= NS) ? 1'b1 : tb_null[s];
        e_addr = (s >= NS) ? off : tb_base[s] + off;
        if (nul) e_code = 1;
        else begin
            if (kind == 0) tbad = !tb_exec[s];
            else if (wr)   tbad = tb_exec[s] || !tb_rw[s];
            else           tbad = tb_exec[s] && !tb_rw[s];
            if (int'(tb_dpl[s]) < cpl) e_code = 2;
            else if (tbad)             e_code = 3;
            else if (off > tb_lim[s])  e_code = 4;
            else                       e_code = 0;
        end
        e_ok = (e_code == 0);
    endtask

    task automatic compare_now(input bit e_done, input bit e_ok, input int e_code,
                               input logic [AW-1:0] e_addr, input string tag);
        n_cmp++;
        if (rsp_done !== e_done || rsp_ok !== e_ok || int'(rsp_fault) != e_code ||
            (e_ok && rsp_addr !== e_addr)) begin
            n_bad++;
            $display("FAIL %s: got done=%0b ok=%0b fault=%0d addr=%h, expected done=%0b ok=%0b fault=%0d addr=%h",
                     tag, rsp_done, rsp_ok, rsp_fault, rsp_addr, e_done, e_ok, e_code, e_addr);
        end
    endtask

    // Called at a falling edge: drive, then check one cycle later
    task automatic issue(input bit v, input int kind, input bit ovr, input int osel,
                         input logic [AW-1:0] off, input bit wr, input int cpl, input string tag);
        bit e_ok; int e_code; logic [AW-1:0] e_addr;
        req_valid   = v;
        req_kind    = 2'(kind);
        req_ovr_en  = ovr;
        req_ovr_sel = SW'(osel);
        req_offset  = off;
        req_write   = wr;
        cur_pl      = 2'(cpl);
        model(v, kind, ovr, osel, off, wr, cpl, e_ok, e_code, e_addr);
        q_done.push_back(v); q_ok.push_back(e_ok); q_code.push_back(e_code);
        q_addr.push_back(e_addr); q_tag.push_back(tag);
        @(negedge clk);
        compare_now(q_done.pop_front(), q_ok.pop_front(), q_code.pop_front(),
                    q_addr.pop_front(), q_tag.pop_front());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        // 0 code RX, 1 stack RW, 2 flat data RW, 3 read-only data, 4 null, 5 PL3 data near top
        tb_base[0] = 32'h0000_1000; tb_lim[0] = 32'h0000_FFFF; tb_exec[0] = 1; tb_rw[0] = 1; tb_dpl[0] = 0; tb_null[0] = 0;
        tb_base[1] = 32'h2000_0000; tb_lim[1] = 32'h0000_0FFF; tb_exec[1] = 0; tb_rw[1] = 1; tb_dpl[1] = 0; tb_null[1] = 0;
        tb_base[2] = 32'h0000_0000; tb_lim[2] = 32'hFFFF_FFFF; tb_exec[2] = 0; tb_rw[2] = 1; tb_dpl[2] = 0; tb_null[2] = 0;
        tb_base[3] = 32'h0000_0300; tb_lim[3] = 32'h0000_00FF; tb_exec[3] = 0; tb_rw[3] = 0; tb_dpl[3] = 0; tb_null[3] = 0;
        tb_base[4] = 32'h0000_4000; tb_lim[4] = 32'hFFFF_FFFF; tb_exec[4] = 0; tb_rw[4] = 1; tb_dpl[4] = 0; tb_null[4] = 1;
        tb_base[5] = 32'hFFFF_FF00; tb_lim[5] = 32'hFFFF_FFFF; tb_exec[5] = 0; tb_rw[5] = 1; tb_dpl[5] = 3; tb_null[5] = 0;

        repeat (3) @(negedge clk);
        compare_now(0, 0, 0, '0, "R1 in reset");
        rst = 1'b0;
        issue(0, 0, 0, 0, 32'h0, 0, 0, "R1 after reset");

        issue(1, 0, 0, 0, 32'h20, 0, 0, "R2 fetch base+offset");
        issue(1, 2, 1, 5, 32'h200, 0, 0, "R2 address wraps");
        issue(1, 1, 0, 0, 32'h10, 1, 0, "R3 stack slot");
        issue(1, 2, 0, 0, 32'h1234_5678, 1, 0, "R3 data slot");
        issue(1, 3, 0, 0, 32'h40, 0, 0, "R3 kind 3 as data");
        issue(1, 2, 1, 3, 32'h5, 0, 0, "R4 override to read-only");
        issue(1, 0, 1, 3, 32'h8, 0, 0, "R4 fetch ignores override");
        issue(1, 1, 1, 2, 32'h8000, 1, 0, "R4 stack override");
        issue(1, 2, 1, 4, 32'h0, 0, 0, "R5 null register");
        issue(1, 2, 1, 6, 32'h0, 0, 0, "R5 index out of range");
        issue(1, 1, 1, 7, 32'h0, 1, 0, "R5 index 7");
        issue(1, 2, 0, 0, 32'h100, 0, 3, "R6 level too low");
        issue(1, 2, 1, 5, 32'h10, 1, 3, "R6 matching level");
        issue(1, 0, 0, 0, 32'h10, 0, 2, "R6 fetch privilege");
        tb_exec[0] = 0;
        issue(1, 0, 0, 0, 32'h10, 0, 0, "R7 fetch non-exec");
        tb_exec[0] = 1;
        issue(1, 0, 0, 0, 32'h10, 1, 0, "R7 fetch ignores write flag");
        issue(1, 2, 1, 3, 32'h10, 1, 0, "R8 write read-only");
        issue(1, 2, 1, 0, 32'h10, 1, 0, "R8 write code");
        issue(1, 2, 1, 0, 32'h10, 0, 0, "R8 read readable code");
        tb_rw[0] = 0;
        issue(1, 2, 1, 0, 32'h10, 0, 0, "R8 read execute-only");
        issue(1, 0, 0, 0, 32'h10, 0, 0, "R8 fetch execute-only");
        tb_rw[0] = 1;
        issue(1, 1, 0, 0, 32'h0FFF, 1, 0, "R9 offset at limit");
        issue(1, 1, 0, 0, 32'h1000, 1, 0, "R9 offset past limit");
        issue(1, 0, 0, 0, 32'h1_0000, 0, 0, "R9 fetch past limit");
        issue(1, 2, 1, 3, 32'h100, 1, 3, "R10 priv over type and limit");
        issue(1, 2, 1, 3, 32'h100, 1, 0, "R10 type over limit");
        issue(1, 2, 1, 4, 32'h0, 1, 3, "R10 null over priv");
        issue(1, 2, 1, 3, 32'h100, 0, 0, "R10 limit alone");
        issue(0, 1, 1, 4, 32'h5, 1, 3, "R11 idle cycle");
        issue(1, 2, 0, 0, 32'h7, 0, 0, "R11 back to back ok");

        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] off;
            off = ($urandom % 2 == 0) ? ($urandom % 32'h1_1000) : $urandom;
            issue(($urandom % 5) != 0, int'($urandom % 4), bit'($urandom % 2),
                  int'($urandom % 8), off, bit'($urandom % 2), int'($urandom % 4),
                  "R10 mixed traffic");
        end

        finish_run();
    end

endmodule